// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the software-visible control and status state of a multichannel DMA descriptor engine. A host reaches it over a simple register bus that carries a 10-bit register number, separate read and write strobes, and 32-bit data. The block stores a global configuration word, an error status word and an interrupt-enable word. It also keeps per-direction channel-active, end-of-buffer and descriptor-error words, current-descriptor pointers for every transmit and receive channel, and a buffer-size byte for every receive channel. The transmit and receive channel counts are parameters of up to 32 each.

The engine that fetches descriptors and moves data sits outside this block. It raises status bits through one-cycle set pulses, one bit per channel, and it reads the configuration, enables, active masks, pointers and sizes from flat output ports. Software clears status bits by writing ones. Writing the configuration word with bit 31 set resets the control and status state and then stores the rest of the written word.

Top module: `dmaRegFile`

## Requirements
- R1: After a hardware reset the configuration word (0x180) reads 0x0007C000. The error status (0x181), interrupt enable (0x182), transmit active (0x184), transmit end-of-buffer (0x186), transmit descriptor-error (0x187), receive active (0x190), receive end-of-buffer (0x192) and receive descriptor-error (0x193) words all read zero.
- R2: A write to 0x180 stores the written value ANDed with 0x00FFC087.
- R3: A write to 0x180 with bit 31 set first returns the error, enable, active, end-of-buffer and descriptor-error words to zero, and then stores the masked configuration.
- R4: The error, both end-of-buffer and both descriptor-error words clear on a write of one: each written 1 clears its bit and each written 0 leaves its bit unchanged.
- R5: A one-cycle set pulse on bit n of a status input sets bit n of the matching word. A set in the same cycle as a clearing write or a software reset wins, so the bit reads 1 afterwards.
- R6: The interrupt-enable word is fully read/write. The active words keep only bits below their direction's channel count and read zero above them.
- R7: The transmit pointer of channel n sits at 0x1A0+n for n below the transmit count, and it stores and returns all 32 bits.
- R8: The receive pointer of channel n sits at 0x1C0+n and stores all 32 bits. The receive size of channel n sits at 0x1E0+n, keeps bits 7:0 and reads zero in bits 31:8. Both exist only for n below the receive count.
- R9: Pointer and size registers are changed only by bus writes, never by a hardware or software reset.
- R10: A read of any undecoded number, including a per-channel slot at or beyond the channel count, returns zero, and a write there changes no register.
- R11: Read data appears on the cycle after the read strobe and is zero in every other cycle. Read and write strobes are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| addr | input | 10 | Register number |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| errSet | input | 32 | Error status set pulses |
| txEobSet | input | TX_CH | Transmit end-of-buffer set pulses |
| txDerrSet | input | TX_CH | Transmit descriptor-error set pulses |
| rxEobSet | input | RX_CH | Receive end-of-buffer set pulses |
| rxDerrSet | input | RX_CH | Receive descriptor-error set pulses |
| rdData | output | 32 | Registered read data |
| cfgOut | output | 32 | Current configuration word |
| intEnOut | output | 32 | Current interrupt-enable word |
| txActOut | output | TX_CH | Transmit channel-active mask |
| rxActOut | output | RX_CH | Receive channel-active mask |
| txPtrFlat | output | 32*TX_CH | Transmit pointers, channel n in bits 32n+31:32n |
| rxPtrFlat | output | 32*RX_CH | Receive pointers, channel n in bits 32n+31:32n |
| rxSizeFlat | output | 8*RX_CH | Receive sizes, channel n in bits 8n+7:8n |

## Verification
Two operations can land on a status bit in the same cycle: a set pulse from the engine, and a clearing write or software reset from software. The bench drives a set pulse together with a one-write to the receive descriptor-error word, and another set pulse together with a bit-31 configuration write. Reading back afterwards must show the set bits at 1 while every other cleared bit stays at 0. A full read sweep of 0x180 to 0x1FF, taken after writes to every per-channel slot and to undecoded numbers, is compared with an arithmetic model. That sweep shows whether slots beyond the channel counts alias onto real channels.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 8;

  localparam logic [ADDR_W-1:0] A_CFG    = 10'h180;
  localparam logic [ADDR_W-1:0] A_ERR    = 10'h181;
  localparam logic [ADDR_W-1:0] A_IEN    = 10'h182;
  localparam logic [ADDR_W-1:0] A_TXACT  = 10'h184;
  localparam logic [ADDR_W-1:0] A_TXEOB  = 10'h186;
  localparam logic [ADDR_W-1:0] A_TXDERR = 10'h187;
  localparam logic [ADDR_W-1:0] A_RXACT  = 10'h190;
  localparam logic [ADDR_W-1:0] A_RXEOB  = 10'h192;
  localparam logic [ADDR_W-1:0] A_RXDERR = 10'h193;
  localparam logic [ADDR_W-1:0] A_TXPTR  = 10'h1A0;
  localparam logic [ADDR_W-1:0] A_RXPTR  = 10'h1C0;
  localparam logic [ADDR_W-1:0] A_RXSIZE = 10'h1E0;

  localparam logic [DATA_W-1:0] CFG_RESET = 32'h0007C000;
  localparam logic [DATA_W-1:0] CFG_MASK  = 32'h00FFC087;
  localparam int SWRST_BIT = 31;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_ERR, SEL_IEN, SEL_TXACT, SEL_TXEOB, SEL_TXDERR,
    SEL_RXACT, SEL_RXEOB, SEL_RXDERR, SEL_TXPTR, SEL_RXPTR, SEL_RXSIZE
  } regSel_e;

  typedef struct packed {
    logic    wr;
    logic    rd;
    logic    swReset;
    regSel_e sel;
    logic [4:0] chIdx;
  } regStrb_t;
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              wrTopBit,
  output regStrb_t          strb
);
  localparam logic [4:0] TXPTR_BLK  = A_TXPTR[ADDR_W-1:5];
  localparam logic [4:0] RXPTR_BLK  = A_RXPTR[ADDR_W-1:5];
  localparam logic [4:0] RXSIZE_BLK = A_RXSIZE[ADDR_W-1:5];

  regSel_e sel;
  logic [4:0] chOff;
  logic [4:0] blk;

  assign chOff = addr[4:0];
  assign blk   = addr[ADDR_W-1:5];

  always_comb begin
    sel = SEL_NONE;
    case (addr)
      A_CFG:    sel = SEL_CFG;
      A_ERR:    sel = SEL_ERR;
      A_IEN:    sel = SEL_IEN;
      A_TXACT:  sel = SEL_TXACT;
      A_TXEOB:  sel = SEL_TXEOB;
      A_TXDERR: sel = SEL_TXDERR;
      A_RXACT:  sel = SEL_RXACT;
      A_RXEOB:  sel = SEL_RXEOB;
      A_RXDERR: sel = SEL_RXDERR;
      default: begin
        if (blk == TXPTR_BLK && int'(chOff) < TX_CH)       sel = SEL_TXPTR;
        else if (blk == RXPTR_BLK && int'(chOff) < RX_CH)  sel = SEL_RXPTR;
        else if (blk == RXSIZE_BLK && int'(chOff) < RX_CH) sel = SEL_RXSIZE;
      end
    endcase
  end

  always_comb begin
    strb.wr      = wrEn;
    strb.rd      = rdEn;
    strb.sel     = sel;
    strb.chIdx   = chOff;
    strb.swReset = wrEn && (sel == SEL_CFG) && wrTopBit;
  end

  // R11
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));
endmodule

// File: rtl/dmaRegData.sv
module dmaRegData
  import dmaRegPkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrb_t                strb,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [DATA_W-1:0]       errSet,
  input  logic [TX_CH-1:0]        txEobSet,
  input  logic [TX_CH-1:0]        txDerrSet,
  input  logic [RX_CH-1:0]        rxEobSet,
  input  logic [RX_CH-1:0]        rxDerrSet,
  output logic [DATA_W-1:0]       rdData,
  output logic [DATA_W-1:0]       cfgOut,
  output logic [DATA_W-1:0]       intEnOut,
  output logic [TX_CH-1:0]        txActOut,
  output logic [RX_CH-1:0]        rxActOut,
  output logic [DATA_W*TX_CH-1:0] txPtrFlat,
  output logic [DATA_W*RX_CH-1:0] rxPtrFlat,
  output logic [SIZE_W*RX_CH-1:0] rxSizeFlat
);
  localparam int TX_IW = (TX_CH > 1) ? $clog2(TX_CH) : 1;
  localparam int RX_IW = (RX_CH > 1) ? $clog2(RX_CH) : 1;

  logic [DATA_W-1:0] cfgQ, errQ, intEnQ;
  logic [TX_CH-1:0]  txActQ, txEobQ, txDerrQ;
  logic [RX_CH-1:0]  rxActQ, rxEobQ, rxDerrQ;
  logic [DATA_W-1:0] txPtrQ [TX_CH];
  logic [DATA_W-1:0] rxPtrQ [RX_CH];
  logic [SIZE_W-1:0] rxSizeQ [RX_CH];

  logic hitCfg, hitErr, hitIen, hitTxAct, hitTxEob, hitTxDerr;
  logic hitRxAct, hitRxEob, hitRxDerr, hitTxPtr, hitRxPtr, hitRxSize;
  assign hitCfg    = strb.wr && strb.sel == SEL_CFG;
  assign hitErr    = strb.wr && strb.sel == SEL_ERR;
  assign hitIen    = strb.wr && strb.sel == SEL_IEN;
  assign hitTxAct  = strb.wr && strb.sel == SEL_TXACT;
  assign hitTxEob  = strb.wr && strb.sel == SEL_TXEOB;
  assign hitTxDerr = strb.wr && strb.sel == SEL_TXDERR;
  assign hitRxAct  = strb.wr && strb.sel == SEL_RXACT;
  assign hitRxEob  = strb.wr && strb.sel == SEL_RXEOB;
  assign hitRxDerr = strb.wr && strb.sel == SEL_RXDERR;
  assign hitTxPtr  = strb.wr && strb.sel == SEL_TXPTR;
  assign hitRxPtr  = strb.wr && strb.sel == SEL_RXPTR;
  assign hitRxSize = strb.wr && strb.sel == SEL_RXSIZE;

  // Control words: plain write, cleared by software reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= CFG_RESET;
      intEnQ <= '0;
      txActQ <= '0;
      rxActQ <= '0;
    end else begin
      if (strb.swReset) begin
        intEnQ <= '0;
        txActQ <= '0;
        rxActQ <= '0;
      end
      if (hitCfg)   cfgQ   <= wrData & CFG_MASK;
      if (hitIen)   intEnQ <= wrData;
      if (hitTxAct) txActQ <= wrData[TX_CH-1:0];
      if (hitRxAct) rxActQ <= wrData[RX_CH-1:0];
    end
  end

  // Status words: clear on written one, engine set has priority
  logic [DATA_W-1:0] errNext;
  logic [TX_CH-1:0]  txEobNext, txDerrNext;
  logic [RX_CH-1:0]  rxEobNext, rxDerrNext;

  always_comb begin
    errNext    = ((strb.swReset ? '0 : errQ)    & ~(hitErr    ? wrData : '0)) | errSet;
    txEobNext  = ((strb.swReset ? '0 : txEobQ)  & ~(hitTxEob  ? wrData[TX_CH-1:0] : '0)) | txEobSet;
    txDerrNext = ((strb.swReset ? '0 : txDerrQ) & ~(hitTxDerr ? wrData[TX_CH-1:0] : '0)) | txDerrSet;
    rxEobNext  = ((strb.swReset ? '0 : rxEobQ)  & ~(hitRxEob  ? wrData[RX_CH-1:0] : '0)) | rxEobSet;
    rxDerrNext = ((strb.swReset ? '0 : rxDerrQ) & ~(hitRxDerr ? wrData[RX_CH-1:0] : '0)) | rxDerrSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ    <= '0;
      txEobQ  <= '0;
      txDerrQ <= '0;
      rxEobQ  <= '0;
      rxDerrQ <= '0;
    end else begin
      errQ    <= errNext;
      txEobQ  <= txEobNext;
      txDerrQ <= txDerrNext;
      rxEobQ  <= rxEobNext;
      rxDerrQ <= rxDerrNext;
    end
  end

  // Per-channel windows: untouched by either reset
  for (genvar t = 0; t < TX_CH; t++) begin : gTxPtr
    always_ff @(posedge clk) begin
      if (hitTxPtr && strb.chIdx == 5'(t)) txPtrQ[t] <= wrData;
    end
    assign txPtrFlat[t*DATA_W +: DATA_W] = txPtrQ[t];
  end

  for (genvar r = 0; r < RX_CH; r++) begin : gRxCh
    always_ff @(posedge clk) begin
      if (hitRxPtr && strb.chIdx == 5'(r))  rxPtrQ[r]  <= wrData;
      if (hitRxSize && strb.chIdx == 5'(r)) rxSizeQ[r] <= wrData[SIZE_W-1:0];
    end
    assign rxPtrFlat[r*DATA_W +: DATA_W]  = rxPtrQ[r];
    assign rxSizeFlat[r*SIZE_W +: SIZE_W] = rxSizeQ[r];
  end

  // Read path
  logic [DATA_W-1:0] txActW, txEobW, txDerrW, rxActW, rxEobW, rxDerrW, rdMux;
  always_comb begin
    txActW = '0;  txActW[TX_CH-1:0]  = txActQ;
    txEobW = '0;  txEobW[TX_CH-1:0]  = txEobQ;
    txDerrW = '0; txDerrW[TX_CH-1:0] = txDerrQ;
    rxActW = '0;  rxActW[RX_CH-1:0]  = rxActQ;
    rxEobW = '0;  rxEobW[RX_CH-1:0]  = rxEobQ;
    rxDerrW = '0; rxDerrW[RX_CH-1:0] = rxDerrQ;
  end

  always_comb begin
    rdMux = '0;
    case (strb.sel)
      SEL_CFG:    rdMux = cfgQ;
      SEL_ERR:    rdMux = errQ;
      SEL_IEN:    rdMux = intEnQ;
      SEL_TXACT:  rdMux = txActW;
      SEL_TXEOB:  rdMux = txEobW;
      SEL_TXDERR: rdMux = txDerrW;
      SEL_RXACT:  rdMux = rxActW;
      SEL_RXEOB:  rdMux = rxEobW;
      SEL_RXDERR: rdMux = rxDerrW;
      SEL_TXPTR:  rdMux = txPtrQ[strb.chIdx[TX_IW-1:0]];
      SEL_RXPTR:  rdMux = rxPtrQ[strb.chIdx[RX_IW-1:0]];
      SEL_RXSIZE: rdMux = {{(DATA_W-SIZE_W){1'b0}}, rxSizeQ[strb.chIdx[RX_IW-1:0]]};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rd ? rdMux : '0;
  end

  assign cfgOut   = cfgQ;
  assign intEnOut = intEnQ;
  assign txActOut = txActQ;
  assign rxActOut = rxActQ;

  // R2
  cfg_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitCfg |=> cfgQ == ($past(wrData) & CFG_MASK));
  // R3
  swreset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.swReset |=> (intEnQ == '0 && txActQ == '0 && rxActQ == '0));
  // R4
  rxderr_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitRxDerr |=> ((rxDerrQ & $past(wrData[RX_CH-1:0]) & ~$past(rxDerrSet)) == '0));
  // R5
  txeob_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|txEobSet) |=> ((txEobQ & $past(txEobSet)) == $past(txEobSet)));
  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.sel == SEL_NONE) |=> rdData == '0);
  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rd |=> rdData == '0);
endmodule

// File: rtl/dmaRegFile.sv
module dmaRegFile
  import dmaRegPkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    rdEn,
  input  logic                    wrEn,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [DATA_W-1:0]       errSet,
  input  logic [TX_CH-1:0]        txEobSet,
  input  logic [TX_CH-1:0]        txDerrSet,
  input  logic [RX_CH-1:0]        rxEobSet,
  input  logic [RX_CH-1:0]        rxDerrSet,
  output logic [DATA_W-1:0]       rdData,
  output logic [DATA_W-1:0]       cfgOut,
  output logic [DATA_W-1:0]       intEnOut,
  output logic [TX_CH-1:0]        txActOut,
  output logic [RX_CH-1:0]        rxActOut,
  output logic [DATA_W*TX_CH-1:0] txPtrFlat,
  output logic [DATA_W*RX_CH-1:0] rxPtrFlat,
  output logic [SIZE_W*RX_CH-1:0] rxSizeFlat
);
  regStrb_t strb;

  initial begin
    if (TX_CH < 1 || TX_CH > 32 || RX_CH < 1 || RX_CH > 32)
      $error("channel counts must lie in 1..32");
  end

  dmaRegCtrl #(.TX_CH(TX_CH), .RX_CH(RX_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrTopBit(wrData[SWRST_BIT]), .strb(strb)
  );

  dmaRegData #(.TX_CH(TX_CH), .RX_CH(RX_CH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .errSet(errSet), .txEobSet(txEobSet), .txDerrSet(txDerrSet),
    .rxEobSet(rxEobSet), .rxDerrSet(rxDerrSet),
    .rdData(rdData), .cfgOut(cfgOut), .intEnOut(intEnOut),
    .txActOut(txActOut), .rxActOut(rxActOut),
    .txPtrFlat(txPtrFlat), .rxPtrFlat(rxPtrFlat), .rxSizeFlat(rxSizeFlat)
  );
endmodule

// File: tb/tb_dmaRegFile.sv
`timescale 1ns/1ps
module tb_dmaRegFile;
  localparam int TX = 4;
  localparam int RX = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] addr = '0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [31:0] wrData = '0, errSet = '0;
  logic [TX-1:0] txEobSet = '0, txDerrSet = '0;
  logic [RX-1:0] rxEobSet = '0, rxDerrSet = '0;
  logic [31:0] rdData, cfgOut, intEnOut;
  logic [TX-1:0] txActOut;
  logic [RX-1:0] rxActOut;
  logic [32*TX-1:0] txPtrFlat;
  logic [32*RX-1:0] rxPtrFlat;
  logic [8*RX-1:0] rxSizeFlat;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  dmaRegFile #(.TX_CH(TX), .RX_CH(RX)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .errSet(errSet), .txEobSet(txEobSet), .txDerrSet(txDerrSet),
    .rxEobSet(rxEobSet), .rxDerrSet(rxDerrSet), .rdData(rdData),
    .cfgOut(cfgOut), .intEnOut(intEnOut), .txActOut(txActOut), .rxActOut(rxActOut),
    .txPtrFlat(txPtrFlat), .rxPtrFlat(rxPtrFlat), .rxSizeFlat(rxSizeFlat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic doWr, input logic [9:0] a, input logic [31:0] d,
                       input logic [31:0] es, input logic [TX-1:0] te, input logic [TX-1:0] td,
                       input logic [RX-1:0] re, input logic [RX-1:0] rd);
    @(negedge clk);
    addr = a; wrData = d; wrEn = doWr;
    errSet = es; txEobSet = te; txDerrSet = td; rxEobSet = re; rxDerrSet = rd;
    @(negedge clk);
    wrEn = 1'b0; errSet = '0; txEobSet = '0; txDerrSet = '0; rxEobSet = '0; rxDerrSet = '0;
  endtask

  task automatic busWr(input logic [9:0] a, input logic [31:0] d);
    drive(1'b1, a, d, '0, '0, '0, '0, '0);
  endtask

  task automatic busRd(input logic [9:0] a, output logic [31:0] r);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    r = rdData;
  endtask

  task automatic rdChk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] r;
    busRd(a, r);
    chk(req, r, exp);
  endtask

  task automatic hwReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // Model of a full read after hardware reset plus window writes
  function automatic logic [31:0] expSweep(input int a);
    if (a == 'h180) return 32'h0007C000;
    if (a >= 'h1A0 && a < 'h1A0 + TX) return pat(a);
    if (a >= 'h1C0 && a < 'h1C0 + RX) return pat(a);
    if (a >= 'h1E0 && a < 'h1E0 + RX) return pat(a) & 32'h000000FF;
    return 32'h0;
  endfunction

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rdChk("R1 cfg", 10'h180, 32'h0007C000);
    foreach (rv[i]) if (i < 0) rv = '0;
    rdChk("R1 err", 10'h181, 0);
    rdChk("R1 ien", 10'h182, 0);
    rdChk("R1 txact", 10'h184, 0);
    rdChk("R1 txeob", 10'h186, 0);
    rdChk("R1 txderr", 10'h187, 0);
    rdChk("R1 rxact", 10'h190, 0);
    rdChk("R1 rxeob", 10'h192, 0);
    rdChk("R1 rxderr", 10'h193, 0);
    // R11 data returns to zero the cycle after
    @(negedge clk);
    chk("R11 idle zero", rdData, 0);

    // R2 configuration masking
    busWr(10'h180, 32'h7FFFFFFF);
    rdChk("R2 cfg ones", 10'h180, 32'h00FFC087);
    busWr(10'h180, 32'h12345678);
    rdChk("R2 cfg pattern", 10'h180, 32'h12345678 & 32'h00FFC087);
    chk("R2 cfgOut", cfgOut, 32'h12345678 & 32'h00FFC087);

    // R6 plain words
    busWr(10'h182, 32'hDEADBEEF);
    rdChk("R6 ien", 10'h182, 32'hDEADBEEF);
    busWr(10'h184, 32'hFFFFFFFF);
    rdChk("R6 txact", 10'h184, (32'h1 << TX) - 1);
    busWr(10'h190, 32'hFFFFFFFF);
    rdChk("R6 rxact", 10'h190, (32'h1 << RX) - 1);

    // R5 sets then R4 clear-on-one
    drive(1'b0, 10'h0, 0, 32'h0000F0F0, 4'b1011, 4'b0110, 2'b11, 2'b11);
    rdChk("R5 txeob set", 10'h186, 32'hB);
    busWr(10'h186, 32'h3);
    rdChk("R4 txeob w1c", 10'h186, 32'hB & ~32'h3);
    busWr(10'h187, 32'h4);
    rdChk("R4 txderr w1c", 10'h187, 32'h6 & ~32'h4);
    busWr(10'h192, 32'h2);
    rdChk("R4 rxeob w1c", 10'h192, 32'h3 & ~32'h2);
    busWr(10'h193, 32'h1);
    rdChk("R4 rxderr w1c", 10'h193, 32'h3 & ~32'h1);
    busWr(10'h181, 32'h000000F0);
    rdChk("R4 err w1c", 10'h181, 32'h0000F0F0 & ~32'h000000F0);

    // R5 set and clear in the same cycle: set wins
    drive(1'b1, 10'h193, 32'h3, '0, '0, '0, '0, 2'b01);
    rdChk("R5 set beats clear", 10'h193, 32'h1);

    // R9 pointers before software reset
    busWr(10'h1A0, 32'hCAFEF00D);
    busWr(10'h1E1, 32'h12345678);
    rdChk("R7 txptr0", 10'h1A0, 32'hCAFEF00D);

    // R3 software reset with a concurrent error set (R5)
    drive(1'b1, 10'h180, 32'h80000001, 32'h00000100, '0, '0, '0, '0);
    rdChk("R3 cfg after swreset", 10'h180, 32'h80000001 & 32'h00FFC087);
    rdChk("R5 err set beats swreset", 10'h181, 32'h00000100);
    rdChk("R3 ien cleared", 10'h182, 0);
    rdChk("R3 txact cleared", 10'h184, 0);
    rdChk("R3 rxact cleared", 10'h190, 0);
    rdChk("R3 txeob cleared", 10'h186, 0);
    rdChk("R3 rxderr cleared", 10'h193, 0);
    rdChk("R9 txptr kept swreset", 10'h1A0, 32'hCAFEF00D);
    rdChk("R8 R9 size kept swreset", 10'h1E1, 32'h00000078);

    // R9 hardware reset keeps pointers
    hwReset();
    rdChk("R1 cfg after hw reset", 10'h180, 32'h0007C000);
    rdChk("R9 txptr kept hw reset", 10'h1A0, 32'hCAFEF00D);
    chk("R9 rxSizeFlat", 32'(rxSizeFlat[15:8]), 32'h78);

    // Sweep: R7 R8 R10
    hwReset();
    for (int a = 'h1A0; a < 'h200; a++) busWr(10'(a), pat(a));
    for (int a = 'h183; a < 'h1A0; a++) begin
      if (a != 'h184 && a != 'h186 && a != 'h187 && a != 'h190 && a != 'h192 && a != 'h193)
        busWr(10'(a), 32'hFFFFFFFF);
    end
    for (int a = 'h180; a < 'h200; a++) begin
      if (a >= 'h1A0 && a < 'h1C0)      rdChk("R7 R10 tx window", 10'(a), expSweep(a));
      else if (a >= 'h1C0 && a < 'h1E0) rdChk("R8 R10 rx ptr window", 10'(a), expSweep(a));
      else if (a >= 'h1E0)              rdChk("R8 R10 rx size window", 10'(a), expSweep(a));
      else                              rdChk("R10 R1 fixed words", 10'(a), expSweep(a));
    end
    chk("R7 txPtrFlat ch3", txPtrFlat[127:96], pat('h1A3));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule